// File: doc/BRIEF.md
# Crossbar Column Post-Processing Engine

This block turns the raw 8-bit converter codes of an analog matrix-vector multiply into finished layer activations. Each code arrives on a valid/ready stream together with the index of the column it came from. The engine multiplies the code by that column's scale factor and adds that column's bias. It saturates the result and reduces it to an 8-bit value. It then applies the selected activation: pass-through, ReLU, or a lookup in one of two tables (sigmoid, or the exponential used for softmax). The finished byte leaves on a second valid/ready stream with its column index, ready to be written into the local activation buffer.

Per-column scale and bias values and both activation tables are loaded through one write port. A separate 2-bit write sets the activation mode. The datapath has five register stages and a fixed latency. A stalled output freezes every stage at once, so no sample is lost or repeated.

Top module: `colpost_engine`

## Requirements
- R1: After reset `out_valid` is low, `in_ready` is high, every column's scale is 1.0 (0x10), every bias is 0, both tables hold 0, and the mode is pass-through (0).
- R2: A write with `cfg_sel`=0 sets the scale of column `cfg_addr` to `cfg_wdata[7:0]`, read as unsigned with 4 fractional bits; the scaled value is floor(code × scale / 16).
- R3: A write with `cfg_sel`=1 sets the bias of column `cfg_addr` to the signed `cfg_wdata[15:0]`; scaled value plus bias is saturated to the range -32768..32767.
- R4: The saturated value s is reduced to r = floor(s / 256) (arithmetic shift right by 8, range -128..127); in mode 0 `out_act` is r as a two's-complement byte.
- R5: In mode 1 `out_act` is 0 when r is negative, otherwise r.
- R6: In mode 2 `out_act` is sigmoid-table entry r+128; writes with `cfg_sel`=2 set entry `cfg_addr[7:0]` to `cfg_wdata[7:0]`.
- R7: In mode 3 `out_act` is exponential-table entry r+128; writes with `cfg_sel`=3 set entry `cfg_addr[7:0]` to `cfg_wdata[7:0]`.
- R8: With `out_ready` held high, a sample accepted on one clock edge is presented on the outputs right after the fourth edge that follows, which is the fifth cycle counting the accepting cycle.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `out_col` and `out_act` hold; every accepted sample leaves exactly once, in acceptance order.
- R10: A mode write (`mode_we`) takes effect only when no sample is in flight; it is then used by any sample accepted in the same cycle or later; otherwise it is ignored.
- R11: A scale or bias write to a column in the same cycle as a sample of that column is accepted is not seen by that sample; the next sample of that column uses the new value.
- R12: `out_col` carries the column index that came in with the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Engine can accept a sample |
| in_col | input | 8 | Column index of the input sample |
| in_code | input | 8 | Unsigned converter code |
| out_valid | output | 1 | Activation valid |
| out_ready | input | 1 | Downstream buffer can take the activation |
| out_col | output | 8 | Column index of the activation |
| out_act | output | 8 | Activation byte |
| cfg_we | input | 1 | Coefficient or table write strobe |
| cfg_sel | input | 2 | Write target: 0 scale, 1 bias, 2 sigmoid table, 3 exponential table |
| cfg_addr | input | 8 | Column index or table entry |
| cfg_wdata | input | 16 | Write data |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode: 0 pass-through, 1 ReLU, 2 sigmoid, 3 exponential |

## Verification
Two pairs of events can fall in one cycle. The first is a mode write together with the acceptance of a sample. The second is a scale write together with the acceptance of a sample for the same column. The bench raises both strobes in the same cycle on an idle pipeline. It expects the new mode on that sample but the old scale, and a follow-up sample shows the new scale. A mode write issued one cycle after a sample enters is also checked: it must be dropped, which shows up as an unchanged mode on a sample sent after the pipeline drains.

// File: rtl/colpost_pkg.sv
package colpost_pkg;

    typedef enum logic [1:0] {
        ACT_PASS = 2'd0,
        ACT_RELU = 2'd1,
        ACT_SIGM = 2'd2,
        ACT_EXPO = 2'd3
    } act_mode_e;

    typedef enum logic [1:0] {
        TGT_SCALE = 2'd0,
        TGT_BIAS  = 2'd1,
        TGT_SIGM  = 2'd2,
        TGT_EXPO  = 2'd3
    } cfg_tgt_e;

    localparam int TAB_SIGM   = 0;
    localparam int TAB_EXPO   = 1;
    localparam int NUM_TABLES = 2;

endpackage

// File: rtl/colpost_coef_store.sv
module colpost_coef_store #(
    parameter int COLS       = 256,
    parameter int COL_W      = 8,
    parameter int SCALE_W    = 8,
    parameter int SCALE_FRAC = 4,
    parameter int BIAS_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_scale,
    input  logic               wr_bias,
    input  logic [COL_W-1:0]   wr_addr,
    input  logic [BIAS_W-1:0]  wr_data,
    input  logic [COL_W-1:0]   rd_addr,
    output logic [SCALE_W-1:0] rd_scale,
    output logic [BIAS_W-1:0]  rd_bias
);

    localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(1) << SCALE_FRAC;

    logic [SCALE_W-1:0] scale_q [COLS];
    logic [SCALE_W-1:0] scale_d [COLS];
    logic [BIAS_W-1:0]  bias_q  [COLS];
    logic [BIAS_W-1:0]  bias_d  [COLS];

    always_comb begin
        scale_d = scale_q;
        bias_d  = bias_q;
        if (wr_scale) begin
            scale_d[wr_addr] = wr_data[SCALE_W-1:0];
        end
        if (wr_bias) begin
            bias_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < COLS; i++) begin
                scale_q[i] <= UNITY;
                bias_q[i]  <= '0;
            end
        end else begin
            scale_q <= scale_d;
            bias_q  <= bias_d;
        end
    end

    // Read happens before the write of the same edge lands (old value seen).
    assign rd_scale = scale_q[rd_addr];
    assign rd_bias  = bias_q[rd_addr];

    p_scale_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_scale |=> (scale_q[$past(wr_addr)] == $past(wr_data[SCALE_W-1:0])));

    p_bias_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bias |=> (bias_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/colpost_act_lut.sv
module colpost_act_lut #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8,
    parameter int NTAB   = 2,
    localparam int DEPTH = 1 << IDX_W,
    localparam int TAB_W = (NTAB > 1) ? $clog2(NTAB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NTAB-1:0]   wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAB_W-1:0]  rd_tab,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] rd_word [NTAB];

    for (genvar t = 0; t < NTAB; t++) begin : g_tab
        logic [DATA_W-1:0] mem_q [DEPTH];
        logic [DATA_W-1:0] mem_d [DEPTH];

        always_comb begin
            mem_d = mem_q;
            if (wr_en[t]) begin
                mem_d[wr_idx] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem_q[i] <= '0;
                end
            end else begin
                mem_q <= mem_d;
            end
        end

        assign rd_word[t] = mem_q[rd_idx];

        p_entry_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[t] |=> (mem_q[$past(wr_idx)] == $past(wr_data)));
    end

    assign rd_data = rd_word[rd_tab];

endmodule

// File: rtl/colpost_sat_add.sv
module colpost_sat_add #(
    parameter int MAG_W  = 12,
    parameter int BIAS_W = 16,
    parameter int SUM_W  = 18
) (
    input  logic [MAG_W-1:0]  mag,
    input  logic [BIAS_W-1:0] bias,
    output logic [BIAS_W-1:0] sat
);

    localparam int HI_W = SUM_W - BIAS_W + 1;
    localparam logic [BIAS_W-1:0] POS_MAX = {1'b0, {(BIAS_W-1){1'b1}}};
    localparam logic [BIAS_W-1:0] NEG_MIN = {1'b1, {(BIAS_W-1){1'b0}}};

    logic [SUM_W-1:0] sum;
    logic [HI_W-1:0]  hi;

    always_comb begin
        sum = {{(SUM_W-MAG_W){1'b0}}, mag}
            + {{(SUM_W-BIAS_W){bias[BIAS_W-1]}}, bias};
        hi  = sum[SUM_W-1:BIAS_W-1];
        if (hi == '0 || hi == '1) begin
            sat = sum[BIAS_W-1:0];
        end else if (!sum[SUM_W-1]) begin
            sat = POS_MAX;
        end else begin
            sat = NEG_MIN;
        end
    end

endmodule

// File: rtl/colpost_engine.sv
module colpost_engine
    import colpost_pkg::*;
#(
    parameter int COLS       = 256,
    parameter int CODE_W     = 8,
    parameter int SCALE_W    = 8,
    parameter int SCALE_FRAC = 4,
    parameter int BIAS_W     = 16,
    parameter int OUT_W      = 8,
    localparam int COL_W     = $clog2(COLS),
    localparam int CFG_AW    = (COL_W > OUT_W) ? COL_W : OUT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COL_W-1:0]  in_col,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [COL_W-1:0]  out_col,
    output logic [OUT_W-1:0]  out_act,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [BIAS_W-1:0] cfg_wdata,
    input  logic              mode_we,
    input  logic [1:0]        mode_wdata
);

    localparam int PROD_W = CODE_W + SCALE_W;
    localparam int MAG_W  = PROD_W - SCALE_FRAC;
    localparam int SUM_W  = ((MAG_W > BIAS_W) ? MAG_W : BIAS_W) + 2;
    localparam int STAGES = 5;
    localparam int TRK_W  = $clog2(STAGES + 1);

    typedef struct packed {
        logic               v1;
        logic [COL_W-1:0]   col1;
        logic [CODE_W-1:0]  code1;
        logic [SCALE_W-1:0] scl1;
        logic [BIAS_W-1:0]  bias1;
        logic               v2;
        logic [COL_W-1:0]   col2;
        logic [MAG_W-1:0]   mag2;
        logic [BIAS_W-1:0]  bias2;
        logic               v3;
        logic [COL_W-1:0]   col3;
        logic [BIAS_W-1:0]  sat3;
        logic               v4;
        logic [COL_W-1:0]   col4;
        logic [OUT_W-1:0]   red4;
        logic               v5;
        logic [COL_W-1:0]   col5;
        logic [OUT_W-1:0]   act5;
        act_mode_e          mode;
    } pipe_t;

    pipe_t st_q, st_d;

    logic               advance;
    logic               accept;
    logic               busy;
    logic [STAGES-1:0]  vld_vec;
    cfg_tgt_e           tgt;
    logic               we_scale, we_bias;
    logic [NUM_TABLES-1:0] tab_we;
    logic [SCALE_W-1:0] rd_scale;
    logic [BIAS_W-1:0]  rd_bias;
    logic [PROD_W-1:0]  prod;
    logic [BIAS_W-1:0]  sat_val;
    logic [OUT_W-1:0]   lut_idx;
    logic [OUT_W-1:0]   lut_val;
    logic [0:0]         lut_tab;
    logic [OUT_W-1:0]   act_val;
    logic [TRK_W-1:0]   track_q, track_d;

    // Configuration decode
    always_comb begin
        tgt                = cfg_tgt_e'(cfg_sel);
        we_scale           = cfg_we && (tgt == TGT_SCALE);
        we_bias            = cfg_we && (tgt == TGT_BIAS);
        tab_we             = '0;
        tab_we[TAB_SIGM]   = cfg_we && (tgt == TGT_SIGM);
        tab_we[TAB_EXPO]   = cfg_we && (tgt == TGT_EXPO);
    end

    colpost_coef_store #(
        .COLS       (COLS),
        .COL_W      (COL_W),
        .SCALE_W    (SCALE_W),
        .SCALE_FRAC (SCALE_FRAC),
        .BIAS_W     (BIAS_W)
    ) u_coef (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_scale (we_scale),
        .wr_bias  (we_bias),
        .wr_addr  (cfg_addr[COL_W-1:0]),
        .wr_data  (cfg_wdata),
        .rd_addr  (in_col),
        .rd_scale (rd_scale),
        .rd_bias  (rd_bias)
    );

    colpost_sat_add #(
        .MAG_W  (MAG_W),
        .BIAS_W (BIAS_W),
        .SUM_W  (SUM_W)
    ) u_sat (
        .mag  (st_q.mag2),
        .bias (st_q.bias2),
        .sat  (sat_val)
    );

    colpost_act_lut #(
        .IDX_W  (OUT_W),
        .DATA_W (OUT_W),
        .NTAB   (NUM_TABLES)
    ) u_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tab_we),
        .wr_idx  (cfg_addr[OUT_W-1:0]),
        .wr_data (cfg_wdata[OUT_W-1:0]),
        .rd_tab  (lut_tab),
        .rd_idx  (lut_idx),
        .rd_data (lut_val)
    );

    // Stage helpers
    always_comb begin
        vld_vec = {st_q.v5, st_q.v4, st_q.v3, st_q.v2, st_q.v1};
        busy    = |vld_vec;
        advance = !st_q.v5 || out_ready;
        accept  = in_valid && advance;
        prod    = PROD_W'(st_q.code1) * PROD_W'(st_q.scl1);
        // Offset-binary index: signed -128..127 maps to 0..255
        lut_idx = {~st_q.red4[OUT_W-1], st_q.red4[OUT_W-2:0]};
        lut_tab = (st_q.mode == ACT_EXPO) ? 1'b1 : 1'b0;
        unique case (st_q.mode)
            ACT_PASS: act_val = st_q.red4;
            ACT_RELU: act_val = st_q.red4[OUT_W-1] ? '0 : st_q.red4;
            default:  act_val = lut_val;
        endcase
    end

    // Next state of the whole pipeline
    always_comb begin
        st_d = st_q;
        if (mode_we && !busy) begin
            st_d.mode = act_mode_e'(mode_wdata);
        end
        if (advance) begin
            st_d.v1 = accept;
            if (accept) begin
                st_d.col1  = in_col;
                st_d.code1 = in_code;
                st_d.scl1  = rd_scale;
                st_d.bias1 = rd_bias;
            end
            st_d.v2    = st_q.v1;
            st_d.col2  = st_q.col1;
            st_d.mag2  = prod[PROD_W-1:SCALE_FRAC];
            st_d.bias2 = st_q.bias1;
            st_d.v3    = st_q.v2;
            st_d.col3  = st_q.col2;
            st_d.sat3  = sat_val;
            st_d.v4    = st_q.v3;
            st_d.col4  = st_q.col3;
            st_d.red4  = st_q.sat3[BIAS_W-1 -: OUT_W];
            st_d.v5    = st_q.v4;
            st_d.col5  = st_q.col4;
            st_d.act5  = act_val;
        end
        track_d = track_q + TRK_W'(accept) - TRK_W'(st_q.v5 && out_ready);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            track_q <= '0;
        end else begin
            st_q    <= st_d;
            track_q <= track_d;
        end
    end

    assign in_ready  = advance;
    assign out_valid = st_q.v5;
    assign out_col   = st_q.col5;
    assign out_act   = st_q.act5;

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_col) && $stable(out_act)));

    p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_no_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(track_q) == $countones(vld_vec)));

    p_mode_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.mode));

    p_relu_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.mode == ACT_RELU) |-> !out_act[OUT_W-1]);

endmodule

// File: tb/colpost_engine_bench.sv
module colpost_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_col = '0;
    logic [7:0]  in_code = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_col;
    logic [7:0]  out_act;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        mode_we = 1'b0;
    logic [1:0]  mode_wdata = '0;

    colpost_engine u_colpost_engine (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_col(in_col), .in_code(in_code),
        .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col), .out_act(out_act),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    col;
        int    act;
        int    acc;
        bit    lat;
        string req;
    } item_t;

    item_t sb[$];
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int scale_m [256];
    int bias_m  [256];
    int sig_m   [256];
    int exp_m   [256];
    int mode_m = 0;
    bit lat_mode = 0;
    bit bp_en = 0;
    logic [7:0] lfsr = 8'hA5;
    bit    hold_pend = 0;
    int    hold_col, hold_act;

    always @(posedge clk) cyc++;

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = bp_en ? lfsr[0] : 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(int col, int code);
        int p, s, r;
        p = (code * scale_m[col]) >> 4;
        s = p + bias_m[col];
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        r = s >>> 8;
        case (mode_m)
            0: return r & 255;
            1: return (r < 0) ? 0 : r;
            2: return sig_m[r + 128];
            default: return exp_m[r + 128];
        endcase
    endfunction

    task automatic push(input int col, input int code, input string req);
        item_t it;
        it.col = col; it.act = model(col, code); it.acc = cyc + 1;
        it.lat = lat_mode; it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) begin
                check(out_valid && out_col == hold_col[7:0] && out_act == hold_act[7:0],
                      "R9 hold", {24'd0, out_act}, hold_act);
            end
            hold_pend = 0;
            if (out_valid) begin
                if (!out_ready) begin
                    hold_pend = 1; hold_col = out_col; hold_act = out_act;
                end else if (sb.size() == 0) begin
                    check(0, "R9 unexpected output", out_col, -1);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(out_act == it.act[7:0], it.req, out_act, it.act);
                    check(out_col == it.col[7:0], "R12 column", out_col, it.col);
                    if (it.lat) check(cyc == it.acc + 4, "R8 latency", cyc - it.acc, 4);
                end
            end
        end
    end

    task automatic send(input int col, input int code, input string req);
        in_valid = 1; in_col = col[7:0]; in_code = code[7:0];
        do @(negedge clk); while (!in_ready);
        push(col, code, req);
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic cfg_write(input int sel, input int addr, input int data);
        cfg_we = 1; cfg_sel = sel[1:0]; cfg_addr = addr[7:0]; cfg_wdata = data[15:0];
        @(negedge clk);
        case (sel)
            0: scale_m[addr] = data & 255;
            1: bias_m[addr] = int'($signed(data[15:0]));
            2: sig_m[addr] = data & 255;
            default: exp_m[addr] = data & 255;
        endcase
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic set_mode(input int m, input bit take);
        mode_we = 1; mode_wdata = m[1:0];
        @(negedge clk);
        if (take) mode_m = m;
        @(posedge clk); #1;
        mode_we = 0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            scale_m[i] = 16; bias_m[i] = 0; sig_m[i] = 0; exp_m[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
        @(posedge clk); #1;

        // R1: defaults (scale 1.0, bias 0, pass-through, tables zero)
        send(9, 255, "R1 default coefficients");
        drain();
        set_mode(3, 1);
        send(9, 40, "R1 table default zero");
        drain();
        set_mode(0, 1);

        // R2/R3/R4: coefficients under pass-through
        cfg_write(0, 4, 8'h28); cfg_write(1, 4, 16'h1000);
        cfg_write(0, 6, 8'h01); cfg_write(1, 6, 16'hFF00);
        cfg_write(0, 1, 8'hFF); cfg_write(1, 1, 16'h4000);
        cfg_write(1, 2, 16'h8000);
        cfg_write(0, 3, 8'hFF); cfg_write(1, 3, 16'h7FFF);
        lat_mode = 1;
        send(4, 200, "R2 scale 2.5");
        send(6, 255, "R4 floor of negative");
        send(1, 255, "R3 large bias");
        send(2, 0, "R3 most negative bias");
        send(3, 255, "R3 positive saturation");
        send(5, 77, "R4 pass-through");
        drain();

        // Tables
        for (int i = 0; i < 256; i++) cfg_write(2, i, (i ^ 8'h5A));
        for (int i = 0; i < 256; i++) cfg_write(3, i, (i * 7 + 3) & 255);

        set_mode(1, 1);
        send(2, 0, "R5 relu negative");
        send(1, 255, "R5 relu positive");
        send(4, 200, "R5 relu small");
        drain();
        set_mode(2, 1);
        send(2, 0, "R6 sigmoid low end");
        send(3, 255, "R6 sigmoid high end");
        send(6, 255, "R6 sigmoid mid");
        drain();
        set_mode(3, 1);
        send(1, 255, "R7 exp");
        send(2, 0, "R7 exp low end");
        drain();

        // R9: random backpressure, back-to-back stream
        lat_mode = 0;
        bp_en = 1;
        for (int i = 0; i < 60; i++) send((i * 37) & 255, (i * 53 + 11) & 255, "R9 stream");
        drain();
        bp_en = 0;
        repeat (2) @(posedge clk); #1;

        // R10: mode write while busy is ignored
        set_mode(1, 1);
        lat_mode = 1;
        send(2, 0, "R10 sample before write");
        set_mode(3, 0);
        drain();
        send(2, 0, "R10 mode unchanged after busy write");
        drain();

        // R10: mode write in the acceptance cycle on an idle pipeline
        mode_we = 1; mode_wdata = 2'd3;
        in_valid = 1; in_col = 8'd2; in_code = 8'd0;
        @(negedge clk);
        mode_m = 3;
        check(in_ready == 1, "R10 idle ready", in_ready, 1);
        push(2, 0, "R10 mode taken with sample");
        @(posedge clk); #1;
        mode_we = 0; in_valid = 0;
        drain();

        // R11: scale write colliding with acceptance of same column
        cfg_we = 1; cfg_sel = 2'd0; cfg_addr = 8'd7; cfg_wdata = 16'h0030;
        in_valid = 1; in_col = 8'd7; in_code = 8'd100;
        @(negedge clk);
        push(7, 100, "R11 old scale in collision");
        scale_m[7] = 8'h30;
        @(posedge clk); #1;
        cfg_we = 0; in_valid = 0;
        send(7, 100, "R11 new scale afterwards");
        drain();

        check(sb.size() == 0, "R9 all delivered", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule